// File: doc/BRIEF.md
# Dual-Width Flash Bus Front End

This block sits between a host bus and the storage of a 16-Mbit parallel flash part. It merges two active-low chip enables into one device-enable, maps each access onto a 16-bit stored word in either byte or word width, and works out which of the 32 blocks of 64 KiB the current byte address falls in. That block index selects a per-block lock bit.

A small write machine takes each accepted write, holds it for a fixed number of busy cycles, and then commits it. While it is busy it pulls the open-drain ready/busy line low. A low level on the power-down/reset pin aborts any pending write, clears every status flag and all lock bits, and raises the deep power-down flag. When the pin is released, the outputs stay invalid until a recovery counter, sized from the clock period, has covered the required 480 ns. A register array stands in for the flash storage.

Top module: `flash_front_end`

## Requirements
- R1: The device is enabled only while `ce0_n` and `ce1_n` are both 0. While it is disabled, `rdata` reads 0 and write and lock requests leave no trace.
- R2: With `wide`=0 (byte mode), `addr[0]`=0 selects bits 7:0 and `addr[0]`=1 selects bits 15:8 of the word at index `addr[4:1]`. A read returns that byte zero-extended on `rdata[7:0]`. A write puts `wdata[7:0]` into that byte lane only.
- R3: With `wide`=1 (word mode), the full 16-bit word at index `addr[4:1]` is read or written, and `addr[0]` has no effect.
- R4: The block index is `addr[20:16]` in both widths, and `blk_locked` shows that block's lock bit. When `lock_req` is accepted it sets that bit and takes priority over `wr_req`. A write to a locked block changes no data, causes no busy period, and sets `sts_err`.
- R5: While `pwd_n` is 0, `deep_pd` is 1. At each clock edge with `pwd_n`=0, a pending write is dropped without a commit, `busy` is cleared, and `sts_err`, `sts_done` and all lock bits are cleared.
- R6: After `pwd_n` rises, or after reset, `data_valid` stays 0 for 47 clock edges and becomes 1 at the 48th edge (480 ns at a 10 ns period). While `data_valid` is 0, `rdata` is 0 and requests are ignored.
- R7: `standby` is 1 exactly when `pwd_n` is 1 and the device is not enabled.
- R8: An accepted write makes `busy` 1 for 4 clock cycles. During that time `rb_pd_n` is 0 and `sts_ready` is 0, reads return the old data, and new requests are ignored. The word is committed at the edge where `busy` falls, and `sts_done` becomes 1 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| pwd_n | input | 1 | Active-low power-down/reset pin |
| ce0_n | input | 1 | First active-low chip enable |
| ce1_n | input | 1 | Second active-low chip enable |
| wide | input | 1 | Width select: 0 byte, 1 word |
| addr | input | 21 | Byte address |
| wdata | input | 16 | Write data (byte mode uses bits 7:0) |
| wr_req | input | 1 | Write request |
| lock_req | input | 1 | Set lock bit of addressed block |
| rdata | output | 16 | Read data |
| data_valid | output | 1 | Outputs valid (recovery done) |
| dev_en | output | 1 | Combined device enable |
| standby | output | 1 | Standby state flag |
| deep_pd | output | 1 | Deep power-down flag |
| busy | output | 1 | Write machine busy |
| rb_pd_n | output | 1 | Active-low pull-down enable for ready/busy |
| sts_ready | output | 1 | Compatible status: write machine ready |
| sts_err | output | 1 | Compatible status: write to locked block |
| sts_done | output | 1 | Global status: a write completed |
| blk_locked | output | 1 | Lock bit of the addressed block |

## Verification
The bench first goes after lane steering. Byte writes into the high lane and then the low lane are each read back in word mode. A design that swapped lanes or wrote both lanes would return a mixed-up word. It probes the recovery window on the exact edge where it ends, which exposes an off-by-one counter. It also checks that a single high chip enable blocks a lock request, which catches an OR in place of an AND. Finally it drops the power-down pin during a busy write and then reads the target word, so a design that commits on abort, or that keeps its lock bits or sticky flags through power-down, is reported.

// File: rtl/flash_fe_pkg.sv
`timescale 1ns/1ps
package flash_fe_pkg;

    typedef enum logic {
        BUS_BYTE = 1'b0,
        BUS_WORD = 1'b1
    } bus_width_e;

    function automatic int unsigned cycles_for_ns(input int unsigned ns, input int unsigned period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/fe_decode.sv
`timescale 1ns/1ps
module fe_decode
    import flash_fe_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 5,
    parameter int IDX_W  = 4
) (
    input  logic              ce0_n,
    input  logic              ce1_n,
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rd_word,
    output logic              dev_en,
    output logic [BLK_W-1:0]  blk_idx,
    output logic [IDX_W-1:0]  word_idx,
    output logic [DATA_W-1:0] wr_mask,
    output logic [DATA_W-1:0] wr_word,
    output logic [DATA_W-1:0] rd_bus
);
    localparam int LANE_W = DATA_W / 2;

    bus_width_e mode;
    logic       hi_lane;

    always_comb begin
        dev_en   = ~ce0_n & ~ce1_n;
        mode     = bus_width_e'(wide);
        hi_lane  = addr[0];
        blk_idx  = addr[ADDR_W-1 -: BLK_W];
        word_idx = addr[IDX_W:1];
        if (mode == BUS_BYTE) begin
            wr_word = {2{wdata[LANE_W-1:0]}};
            wr_mask = hi_lane ? {{LANE_W{1'b1}}, {LANE_W{1'b0}}}
                              : {{LANE_W{1'b0}}, {LANE_W{1'b1}}};
            rd_bus  = hi_lane ? {{LANE_W{1'b0}}, rd_word[DATA_W-1:LANE_W]}
                              : {{LANE_W{1'b0}}, rd_word[LANE_W-1:0]};
        end else begin
            wr_word = wdata;
            wr_mask = '1;
            rd_bus  = rd_word;
        end
    end

endmodule

// File: rtl/fe_recovery.sv
`timescale 1ns/1ps
module fe_recovery #(
    parameter int RECOV_CYC = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwd_n,
    output logic valid
);
    localparam int CNT_W = $clog2(RECOV_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } rec_t;

    rec_t d, q;

    always_comb begin
        d = q;
        if (!pwd_n) begin
            d.cnt = CNT_W'(RECOV_CYC);
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end
        valid = pwd_n && (q.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= CNT_W'(RECOV_CYC);
        end else begin
            q <= d;
        end
    end

    AST_RECOV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwd_n) |=> !valid); // R6
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(RECOV_CYC)); // R6

endmodule

// File: rtl/fe_wsm.sv
`timescale 1ns/1ps
module fe_wsm #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 16,
    parameter int BLK_W  = 5,
    parameter int WR_CYC = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pwd_n,
    input  logic                     go,
    input  logic                     wr_req,
    input  logic                     lock_req,
    input  logic [BLK_W-1:0]         blk_idx,
    input  logic [$clog2(WORDS)-1:0] word_idx,
    input  logic [DATA_W-1:0]        wr_mask,
    input  logic [DATA_W-1:0]        wr_word,
    output logic [DATA_W-1:0]        rd_word,
    output logic                     busy,
    output logic                     err,
    output logic                     done,
    output logic                     blk_locked
);
    localparam int IDX_W  = $clog2(WORDS);
    localparam int NBLK   = 1 << BLK_W;
    localparam int BCNT_W = $clog2(WR_CYC + 1);

    typedef struct packed {
        logic [NBLK-1:0]   lock;
        logic [BCNT_W-1:0] busy_cnt;
        logic [IDX_W-1:0]  pidx;
        logic [DATA_W-1:0] pdata;
        logic [DATA_W-1:0] pmask;
        logic              err;
        logic              done;
    } wsm_t;

    wsm_t              d, q;
    logic [DATA_W-1:0] mem_d [WORDS];
    logic [DATA_W-1:0] mem_q [WORDS];

    always_comb begin
        d     = q;
        mem_d = mem_q;
        if (q.busy_cnt != '0) begin
            d.busy_cnt = q.busy_cnt - 1'b1;
            if (q.busy_cnt == BCNT_W'(1)) begin
                mem_d[q.pidx] = (mem_q[q.pidx] & ~q.pmask) | (q.pdata & q.pmask);
                d.done        = 1'b1;
            end
        end else if (go) begin
            if (lock_req) begin
                d.lock[blk_idx] = 1'b1;
            end else if (wr_req) begin
                if (q.lock[blk_idx]) begin
                    d.err = 1'b1;
                end else begin
                    d.busy_cnt = BCNT_W'(WR_CYC);
                    d.pidx     = word_idx;
                    d.pdata    = wr_word;
                    d.pmask    = wr_mask;
                end
            end
        end
        if (!pwd_n) begin
            mem_d      = mem_q;
            d.busy_cnt = '0;
            d.lock     = '0;
            d.err      = 1'b0;
            d.done     = 1'b0;
        end
        rd_word    = mem_q[word_idx];
        busy       = (q.busy_cnt != '0);
        err        = q.err;
        done       = q.done;
        blk_locked = q.lock[blk_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            q     <= d;
            mem_q <= mem_d;
        end
    end

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !pwd_n |=> (q.busy_cnt == '0) && !q.err && !q.done && (q.lock == '0)); // R5
    AST_LOCKED_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwd_n && go && !busy && wr_req && !lock_req && q.lock[blk_idx]) |=> !busy); // R4
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy_cnt <= BCNT_W'(WR_CYC)); // R8

endmodule

// File: rtl/flash_front_end.sv
`timescale 1ns/1ps
module flash_front_end
    import flash_fe_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int DATA_W   = 16,
    parameter int BLK_W    = 5,
    parameter int WORDS    = 16,
    parameter int CLK_NS   = 10,
    parameter int RECOV_NS = 480,
    parameter int WR_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwd_n,
    input  logic              ce0_n,
    input  logic              ce1_n,
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_req,
    input  logic              lock_req,
    output logic [DATA_W-1:0] rdata,
    output logic              data_valid,
    output logic              dev_en,
    output logic              standby,
    output logic              deep_pd,
    output logic              busy,
    output logic              rb_pd_n,
    output logic              sts_ready,
    output logic              sts_err,
    output logic              sts_done,
    output logic              blk_locked
);
    localparam int IDX_W     = $clog2(WORDS);
    localparam int RECOV_CYC = int'(cycles_for_ns(RECOV_NS, CLK_NS));

    logic [BLK_W-1:0]  blk_idx;
    logic [IDX_W-1:0]  word_idx;
    logic [DATA_W-1:0] wr_mask, wr_word, rd_word, rd_bus;
    logic              en_w, valid_w, busy_w, go;

    fe_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .IDX_W(IDX_W)) u_dec (
        .ce0_n(ce0_n), .ce1_n(ce1_n), .wide(wide), .addr(addr), .wdata(wdata),
        .rd_word(rd_word), .dev_en(en_w), .blk_idx(blk_idx), .word_idx(word_idx),
        .wr_mask(wr_mask), .wr_word(wr_word), .rd_bus(rd_bus)
    );

    fe_recovery #(.RECOV_CYC(RECOV_CYC)) u_rec (
        .clk(clk), .rst_n(rst_n), .pwd_n(pwd_n), .valid(valid_w)
    );

    fe_wsm #(.DATA_W(DATA_W), .WORDS(WORDS), .BLK_W(BLK_W), .WR_CYC(WR_CYC)) u_wsm (
        .clk(clk), .rst_n(rst_n), .pwd_n(pwd_n), .go(go), .wr_req(wr_req),
        .lock_req(lock_req), .blk_idx(blk_idx), .word_idx(word_idx),
        .wr_mask(wr_mask), .wr_word(wr_word), .rd_word(rd_word), .busy(busy_w),
        .err(sts_err), .done(sts_done), .blk_locked(blk_locked)
    );

    always_comb begin
        go         = en_w && valid_w;
        dev_en     = en_w;
        data_valid = valid_w;
        rdata      = go ? rd_bus : '0;
        deep_pd    = ~pwd_n;
        standby    = pwd_n & ~en_w;
        busy       = busy_w;
        rb_pd_n    = ~busy_w;
        sts_ready  = ~busy_w;
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ce0_n || ce1_n) |-> (rdata == '0)); // R1
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (rdata == '0) && !deep_pd); // R7

endmodule

// File: tb/sim_flash_front_end.sv
`timescale 1ns/1ps
module sim_flash_front_end;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwd_n = 1'b1;
    logic        ce0_n = 1'b0;
    logic        ce1_n = 1'b0;
    logic        wide = 1'b1;
    logic [20:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        wr_req = 1'b0;
    logic        lock_req = 1'b0;
    logic [15:0] rdata;
    logic        data_valid, dev_en, standby, deep_pd, busy, rb_pd_n;
    logic        sts_ready, sts_err, sts_done, blk_locked;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    flash_front_end u0 (
        .clk(clk), .rst_n(rst_n), .pwd_n(pwd_n), .ce0_n(ce0_n), .ce1_n(ce1_n),
        .wide(wide), .addr(addr), .wdata(wdata), .wr_req(wr_req), .lock_req(lock_req),
        .rdata(rdata), .data_valid(data_valid), .dev_en(dev_en), .standby(standby),
        .deep_pd(deep_pd), .busy(busy), .rb_pd_n(rb_pd_n), .sts_ready(sts_ready),
        .sts_err(sts_err), .sts_done(sts_done), .blk_locked(blk_locked)
    );

    typedef struct packed {
        logic        wide;
        logic [20:0] addr;
        logic        wr;
        logic [15:0] wdata;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 21'h000004, 1'b1, 16'hA1B2, 16'hA1B2},  // R3 word write, read back
        '{1'b0, 21'h000004, 1'b0, 16'h0000, 16'h00B2},  // R2 low byte
        '{1'b0, 21'h000005, 1'b0, 16'h0000, 16'h00A1},  // R2 high byte
        '{1'b0, 21'h000005, 1'b1, 16'hFF3C, 16'h003C},  // R2 high lane write
        '{1'b1, 21'h000004, 1'b0, 16'h0000, 16'h3CB2},  // R2 other lane kept
        '{1'b1, 21'h000005, 1'b0, 16'h0000, 16'h3CB2},  // R3 addr[0] ignored
        '{1'b0, 21'h000004, 1'b1, 16'h1177, 16'h0077},  // R2 low lane write
        '{1'b1, 21'h000004, 1'b0, 16'h0000, 16'h3C77},  // R2 word view
        '{1'b1, 21'h01000B, 1'b1, 16'h1234, 16'h1234},  // R3 write, odd address
        '{1'b1, 21'h00000A, 1'b0, 16'h0000, 16'h1234}   // R3 index from addr[4:1]
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        #1;
        chk("R6", "valid in reset", data_valid, 0);
        chk("R8", "busy in reset", busy, 0);
        chk("R8", "rb_pd_n in reset", rb_pd_n, 1);
        chk("R5", "err/done in reset", {sts_err, sts_done}, 0);
        rst_n = 1'b1;
        repeat (47) @(negedge clk);
        #1 chk("R6", "valid at edge 47 after reset", data_valid, 0);
        chk("R6", "rdata hidden in recovery", rdata, 0);
        @(negedge clk);
        #1 chk("R6", "valid at edge 48 after reset", data_valid, 1);

        // vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wide   = VECS[i].wide;
            addr   = VECS[i].addr;
            wdata  = VECS[i].wdata;
            wr_req = VECS[i].wr;
            if (VECS[i].wr) begin
                @(negedge clk);
                wr_req = 1'b0;
                while (busy) @(negedge clk);
            end
            #1 chk(VECS[i].wide ? "R3" : "R2", $sformatf("vector %0d", i), rdata, VECS[i].exp);
        end

        // R8 busy timing
        @(negedge clk);
        wide = 1'b1; addr = 21'h000006; wdata = 16'hBEEF; wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        #1 chk("R8", "busy after accept", {busy, rb_pd_n, sts_ready}, 3'b100);
        chk("R8", "old data while busy", rdata, 0);
        repeat (3) @(negedge clk);
        #1 chk("R8", "busy at 4th cycle", busy, 1);
        @(negedge clk);
        #1 chk("R8", "idle after 4 cycles", {busy, rb_pd_n, sts_ready, sts_done}, 4'b0111);
        chk("R8", "committed word", rdata, 16'hBEEF);

        // R1 and R7 enable combining
        ce0_n = 1'b1;
        #1 chk("R1", "ce0 high disables", {dev_en, rdata}, 0);
        chk("R7", "standby ce0 high", standby, 1);
        ce0_n = 1'b0; ce1_n = 1'b1;
        #1 chk("R1", "ce1 high disables", {dev_en, rdata}, 0);
        chk("R7", "standby ce1 high", standby, 1);
        addr = 21'h030000; lock_req = 1'b1;
        @(negedge clk);
        lock_req = 1'b0; ce1_n = 1'b0;
        #1 chk("R1", "lock ignored while disabled", blk_locked, 0);
        chk("R7", "no standby when enabled", standby, 0);

        // R4 lock and rejected write
        addr = 21'h010000; lock_req = 1'b1; wr_req = 1'b1; wdata = 16'h5A5A;
        @(negedge clk);
        lock_req = 1'b0; wr_req = 1'b0;
        #1 chk("R4", "lock beats write, no busy", {blk_locked, busy}, 2'b10);
        addr = 21'h01FFFF;
        #1 chk("R4", "same block top address", blk_locked, 1);
        addr = 21'h020000;
        #1 chk("R4", "next block unlocked", blk_locked, 0);
        addr = 21'h010004; wdata = 16'hDEAD; wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        #1 chk("R4", "locked write: busy,err", {busy, sts_err}, 2'b01);
        addr = 21'h000004;
        #1 chk("R4", "locked write left data", rdata, 16'h3C77);
        wide = 1'b0; addr = 21'h1F0001; lock_req = 1'b1;
        @(negedge clk);
        lock_req = 1'b0; wide = 1'b1; addr = 21'h1FFFFE;
        #1 chk("R4", "byte-mode lock seen in word mode", blk_locked, 1);
        addr = 21'h1E0000;
        #1 chk("R4", "block 30 unlocked", blk_locked, 0);

        // R5 abort during busy write
        addr = 21'h00000E; wdata = 16'h5555; wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0; pwd_n = 1'b0;
        #1 chk("R5", "deep_pd flag", {deep_pd, standby}, 2'b10);
        @(negedge clk);
        #1 chk("R5", "busy cleared", {busy, rb_pd_n}, 2'b01);
        chk("R5", "status cleared", {sts_err, sts_done}, 0);
        chk("R6", "invalid in power-down", {data_valid, rdata}, 0);
        addr = 21'h010000;
        #1 chk("R5", "lock cleared", blk_locked, 0);
        @(negedge clk);
        pwd_n = 1'b1;
        repeat (47) @(negedge clk);
        #1 chk("R6", "valid at edge 47", data_valid, 0);
        wr_req = 1'b1; addr = 21'h000008; wdata = 16'h9999;
        @(negedge clk);
        wr_req = 1'b0;
        #1 chk("R6", "valid at edge 48", data_valid, 1);
        chk("R6", "write during recovery ignored", {busy, rdata}, 0);
        addr = 21'h00000E;
        #1 chk("R5", "aborted write dropped", rdata, 0);

        finish_run();
    end

endmodule